// File: doc/BRIEF.md
# Width-Partitioned SIMD Integer Arithmetic Unit

This block is a 128-bit integer vector arithmetic unit. A lane-size select, given with each operation, splits its single datapath into eight 16-bit, four 32-bit or two 64-bit lanes. Every lane of an operation runs the same opcode. The unit adds, subtracts, multiplies (keeping the low half of each product) or passes operand A through. Carries, borrows and partial products stay inside their own lane.

A new operation may be issued on every clock cycle at any lane width. The result is registered and appears one cycle after issue, with a valid flag beside it. The unit has no internal sequencing states. Its only state is the result register and the valid flag, both cleared by a synchronous reset.

Top module: `simd_alu128`

## Requirements
- R1: With `lane_sz` = 2'b00 the word is eight independent 16-bit lanes. Lane 0 occupies bits [15:0] and lane k occupies bits [16k+15:16k].
- R2: With `lane_sz` = 2'b01 the word is four independent 32-bit lanes. Lane k occupies bits [32k+31:32k].
- R3: With `lane_sz` = 2'b10 the word is two independent 64-bit lanes. Lane k occupies bits [64k+63:64k].
- R4: Opcode 2'b00 adds each lane of `opa` to the same lane of `opb`, modulo 2^lane-width. No carry passes into the next lane.
- R5: Opcode 2'b01 computes `opa` minus `opb` in each lane, modulo 2^lane-width. No borrow passes into the next lane.
- R6: Opcode 2'b10 returns, for each lane, the low lane-width bits of the unsigned product of the two lane values. No partial product crosses a lane.
- R7: Opcode 2'b11 returns `opa` unchanged at every valid lane size.
- R8: With `lane_sz` = 2'b11 (reserved) the result is all zero, whatever the opcode.
- R9: `out_valid` equals `in_valid` one cycle later. `result` holds the outcome of the operation issued one cycle earlier. Operations may be issued on consecutive cycles.
- R10: In a cycle where `in_valid` is low, `result` keeps its previous value.
- R11: A synchronous reset (`rst` high at a clock edge) clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue an operation this cycle |
| lane_sz | input | 2 | Lane width: 00=16, 01=32, 10=64, 11=reserved |
| opcode | input | 2 | 00=add, 01=subtract, 10=multiply-low, 11=pass A |
| opa | input | 128 | Operand A |
| opb | input | 128 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 128 | Registered lane-wise result |

## Verification
The assertions assume that `in_valid`, `lane_sz`, `opcode` and both operands carry known values at every rising edge after reset. They also assume `rst` changes only in step with the clock. Under these assumptions each `$past` comparison sees the operands that were actually issued. The bench drives every input on the falling edge, starting before the first rising edge, so no X reaches a sampling edge. While `in_valid` is low it still drives the operands, changing them to values that would produce a different result, and so exercises the hold rule.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    // Lane width select; the encoding is part of the interface
    typedef enum logic [1:0] {
        LSZ_16  = 2'b00,
        LSZ_32  = 2'b01,
        LSZ_64  = 2'b10,
        LSZ_RSV = 2'b11
    } lane_sz_e;

    // Operation select shared by all lanes
    typedef enum logic [1:0] {
        OP_ADD   = 2'b00,
        OP_SUB   = 2'b01,
        OP_MULLO = 2'b10,
        OP_PASSA = 2'b11
    } alu_op_e;

    // Number of selectable lane widths (16, 32, 64 bits)
    localparam int NUM_WIDTHS = 3;

endpackage

// File: rtl/simd_seg_adder.sv
// Segmented adder: the carry chain runs through 16-bit segments and is cut
// at every segment boundary that starts a new lane for the selected width.
module simd_seg_adder
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SEG_W = 16
) (
    input  lane_sz_e           lane_sz,
    input  logic               sub,
    input  logic [VEC_W-1:0]   a,
    input  logic [VEC_W-1:0]   b_eff,
    output logic [VEC_W-1:0]   sum
);
    localparam int NSEG      = VEC_W / SEG_W;
    localparam int SEGS_P32  = 2;   // segments per 32-bit lane
    localparam int SEGS_P64  = 4;   // segments per 64-bit lane

    logic [NSEG-2:0] co;

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        localparam bit START32 = (i % SEGS_P32) == 0;
        localparam bit START64 = (i % SEGS_P64) == 0;
        logic cin;
        logic lane_start;

        assign lane_start = (lane_sz == LSZ_16)
                          | ((lane_sz == LSZ_32) & START32)
                          | ((lane_sz == LSZ_64) & START64)
                          | (lane_sz == LSZ_RSV);

        if (i == 0) begin : g_first
            assign cin = sub;
        end else begin : g_rest
            assign cin = lane_start ? sub : co[i-1];
        end

        if (i == NSEG - 1) begin : g_top
            assign sum[i*SEG_W +: SEG_W] = a[i*SEG_W +: SEG_W]
                                         + b_eff[i*SEG_W +: SEG_W]
                                         + {{(SEG_W-1){1'b0}}, cin};
        end else begin : g_mid
            assign {co[i], sum[i*SEG_W +: SEG_W]} =
                  {1'b0, a[i*SEG_W +: SEG_W]}
                + {1'b0, b_eff[i*SEG_W +: SEG_W]}
                + {{SEG_W{1'b0}}, cin};
        end
    end

endmodule

// File: rtl/simd_lane_mul.sv
// Per-lane low-half multipliers for each width variant, then a width mux.
module simd_lane_mul
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SEG_W = 16
) (
    input  lane_sz_e           lane_sz,
    input  logic [VEC_W-1:0]   a,
    input  logic [VEC_W-1:0]   b,
    output logic [VEC_W-1:0]   prod
);
    logic [VEC_W-1:0] prod_w [NUM_WIDTHS];

    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
        localparam int W     = SEG_W << k;
        localparam int NLANE = VEC_W / W;
        for (genvar l = 0; l < NLANE; l++) begin : g_lane
            assign prod_w[k][l*W +: W] = a[l*W +: W] * b[l*W +: W];
        end
    end

    always_comb begin
        unique case (lane_sz)
            LSZ_16:  prod = prod_w[0];
            LSZ_32:  prod = prod_w[1];
            LSZ_64:  prod = prod_w[2];
            LSZ_RSV: prod = '0;
            default: prod = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu128.sv
module simd_alu128
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SEG_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         lane_sz,
    input  logic [1:0]         opcode,
    input  logic [VEC_W-1:0]   opa,
    input  logic [VEC_W-1:0]   opb,
    output logic               out_valid,
    output logic [VEC_W-1:0]   result
);
    lane_sz_e         sz;
    alu_op_e          op;
    logic             is_sub;
    logic [VEC_W-1:0] b_eff;
    logic [VEC_W-1:0] add_res;
    logic [VEC_W-1:0] mul_res;
    logic [VEC_W-1:0] nxt_result;

    assign sz     = lane_sz_e'(lane_sz);
    assign op     = alu_op_e'(opcode);
    assign is_sub = (op == OP_SUB);
    assign b_eff  = is_sub ? ~opb : opb;

    simd_seg_adder #(.VEC_W(VEC_W), .SEG_W(SEG_W)) u_add (
        .lane_sz (sz),
        .sub     (is_sub),
        .a       (opa),
        .b_eff   (b_eff),
        .sum     (add_res)
    );

    simd_lane_mul #(.VEC_W(VEC_W), .SEG_W(SEG_W)) u_mul (
        .lane_sz (sz),
        .a       (opa),
        .b       (opb),
        .prod    (mul_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD,
            OP_SUB:   nxt_result = add_res;
            OP_MULLO: nxt_result = mul_res;
            OP_PASSA: nxt_result = opa;
            default:  nxt_result = '0;
        endcase
        if (sz == LSZ_RSV) begin
            nxt_result = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt_result;
            end
        end
    end

endmodule

// File: rtl/simd_alu128_chk.sv
module simd_alu128_chk #(
    parameter int VEC_W = 128
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [1:0]         lane_sz,
    input logic [1:0]         opcode,
    input logic [VEC_W-1:0]   opa,
    input logic [VEC_W-1:0]   opb,
    input logic               out_valid,
    input logic [VEC_W-1:0]   result
);
    // R11: reset clears both outputs
    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R9: valid follows issue by one cycle
    a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10: result held while nothing is issued
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R8: reserved lane size gives zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_sz == 2'b11) |=> result == '0);

    // R7: pass operand A
    a_r7_pass_a: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 2'b11 && lane_sz != 2'b11) |=> result == $past(opa));

    // R4, R1: top 16-bit lane adds on its own
    a_r4_add16_top: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 2'b00 && lane_sz == 2'b00) |=>
        result[127:112] == 16'($past(opa[127:112]) + $past(opb[127:112])));

    // R5, R2: top 32-bit lane subtracts on its own
    a_r5_sub32_top: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 2'b01 && lane_sz == 2'b01) |=>
        result[127:96] == 32'($past(opa[127:96]) - $past(opb[127:96])));

    // R6, R3: upper 64-bit lane keeps the low half of its product
    a_r6_mul64_hi: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 2'b10 && lane_sz == 2'b10) |=>
        result[127:64] == 64'($past(opa[127:64]) * $past(opb[127:64])));

endmodule

bind simd_alu128 simd_alu128_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/simd_alu128_tb.sv
module simd_alu128_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   lane_sz = 2'b00;
    logic [1:0]   opcode = 2'b00;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    simd_alu128 u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lane_sz(lane_sz),
        .opcode(opcode), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result)
    );

    // Reference built from the requirements
    function automatic logic [127:0] model(logic [1:0] op, logic [1:0] sz,
                                           logic [127:0] a, logic [127:0] b);
        logic [127:0] r = '0;
        int w;
        logic [63:0] mask;
        if (sz == 2'b11) return '0;
        w    = 16 << sz;
        mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        for (int l = 0; l < 128 / w; l++) begin
            logic [63:0] ea = 64'(a >> (l * w)) & mask;
            logic [63:0] eb = 64'(b >> (l * w)) & mask;
            logic [63:0] er;
            case (op)
                2'b00:   er = ea + eb;
                2'b01:   er = ea - eb;
                2'b10:   er = ea * eb;
                default: er = ea;
            endcase
            r = r | (128'(er & mask) << (l * w));
        end
        return r;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation and check it one cycle later
    task automatic run_op(string req, logic [1:0] op, logic [1:0] sz,
                          logic [127:0] a, logic [127:0] b);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; lane_sz = sz; opa = a; opb = b;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {127'd0, out_valid}, 128'd1);
        check(req, result, model(op, sz, a, b));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R11 reset valid", {127'd0, out_valid}, 128'd0);
        check("R11 reset result", result, '0);
        rst = 1'b0;
    endtask

    task automatic t_add;
        logic [127:0] ones = {128{1'b1}};
        run_op("R4 R1 add16 carry", 2'b00, 2'b00, ones, {8{16'h0001}});
        run_op("R4 R2 add32 carry", 2'b00, 2'b01, ones, {4{32'h0000_0001}});
        run_op("R4 R3 add64 carry", 2'b00, 2'b10, ones, {2{64'h1}});
        run_op("R4 R2 add32 interior", 2'b00, 2'b01, {4{32'h0000_FFFF}}, {4{32'h0000_0001}});
        run_op("R4 R1 add16 mixed", 2'b00, 2'b00,
               128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
               128'h1111_2222_3333_4444_8000_9000_A000_F00F);
    endtask

    task automatic t_sub;
        run_op("R5 R1 sub16 borrow", 2'b01, 2'b00, '0, {8{16'h0001}});
        run_op("R5 R2 sub32 borrow", 2'b01, 2'b01, {4{32'h0001_0000}}, {4{32'h0000_0001}});
        run_op("R5 R3 sub64 borrow", 2'b01, 2'b10, '0, 128'h1_0000_0000_0000_0001);
        run_op("R5 R2 sub32 mixed", 2'b01, 2'b01,
               128'hDEAD_BEEF_0000_0005_8000_0000_1234_5678,
               128'h0000_BEEF_0000_0007_0000_0001_8765_4321);
    endtask

    task automatic t_mul;
        run_op("R6 R1 mul16", 2'b10, 2'b00, {8{16'hFFFF}}, {8{16'h0003}});
        run_op("R6 R2 mul32", 2'b10, 2'b01,
               128'h0001_0000_FFFF_FFFF_1234_5678_0000_0010,
               128'h0001_0000_0000_0002_0000_0100_8000_0000);
        run_op("R6 R3 mul64", 2'b10, 2'b10,
               128'hFFFF_FFFF_FFFF_FFFF_0000_0001_0000_0001,
               128'hFFFF_FFFF_FFFF_FFFF_0000_0001_0000_0001);
    endtask

    task automatic t_pass;
        logic [127:0] pat = 128'hA5A5_5A5A_0F0F_F0F0_1234_5678_9ABC_DEF0;
        run_op("R7 pass16", 2'b11, 2'b00, pat, ~pat);
        run_op("R7 pass64", 2'b11, 2'b10, pat, '1);
    endtask

    task automatic t_reserved;
        run_op("R8 rsv add", 2'b00, 2'b11, '1, '1);
        run_op("R8 rsv pass", 2'b11, 2'b11, '1, '0);
    endtask

    // Back-to-back issue at all widths
    task automatic t_stream;
        logic [127:0] a_q [6];
        logic [127:0] b_q [6];
        logic [1:0]   s_q [6];
        logic [1:0]   o_q [6];
        for (int i = 0; i < 6; i++) begin
            a_q[i] = {4{32'h9E37_79B9 * (i + 1)}};
            b_q[i] = {4{32'h7F4A_7C15 ^ (i * 32'h0101_0101)}};
            s_q[i] = 2'(i % 3);
            o_q[i] = 2'(i % 4);
        end
        for (int i = 0; i <= 6; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R9 stream valid", {127'd0, out_valid}, 128'd1);
                check("R9 stream", result, model(o_q[i-1], s_q[i-1], a_q[i-1], b_q[i-1]));
            end
            if (i < 6) begin
                in_valid = 1'b1; opcode = o_q[i]; lane_sz = s_q[i];
                opa = a_q[i]; opb = b_q[i];
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_hold;
        logic [127:0] exp;
        run_op("R10 seed", 2'b00, 2'b01, {4{32'h1000_0001}}, {4{32'h0200_0003}});
        exp = model(2'b00, 2'b01, {4{32'h1000_0001}}, {4{32'h0200_0003}});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            opcode = 2'b11; lane_sz = 2'b00; opa = '1; opb = '1;
            check("R10 hold valid", {127'd0, out_valid}, 128'd0);
            check("R10 hold", result, exp);
        end
    endtask

    task automatic t_midreset;
        run_op("R11 pre", 2'b11, 2'b00, '1, '0);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R11 mid valid", {127'd0, out_valid}, 128'd0);
        check("R11 mid result", result, '0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        @(posedge clk);
        t_reset();
        t_add();
        t_sub();
        t_mul();
        t_pass();
        t_reserved();
        t_stream();
        t_hold();
        t_midreset();
        finish_run();
    end

endmodule